// File: doc/BRIEF.md
# Multi-Law Clock Ratio Divider

This block divides a parent clock by a programmable ratio. It produces two outputs: a one-cycle enable pulse at the end of each output period, and a divided clock level. The parent clock runs the block. The divide law is fixed when the block is built, and it is one of four:

- field plus one;
- twice (field plus one);
- a power of two, 2 shifted left by the field;
- a hard constant.

Software loads the divisor field through a 32-bit write strobe. The field sits at a parameter-chosen bit offset and width. Software starts and stops the output through a single gate bit, which arrives on a separate write strobe.

A rewritten divisor never cuts a period short. The counter finishes its current period and loads the new ratio only at the terminal count. In the power-of-two law, a select input marks the parent as the raw oscillator, and the divider is then bypassed to divide-by-one. A readback port shows the ratio the counter is using at that moment.

Top module: `clk_ratio_div`

## Requirements
- R1: With the plus-one law, the effective ratio is field+1.
- R2: With the even law, the effective ratio is 2*(field+1).
- R3: With the power law and `src_is_osc_i` low, the effective ratio is 2 shifted left by the field (a 2-bit field gives 2, 4, 8 or 16).
- R4: With the constant law, the effective ratio is always FIXED_DIV, and divisor writes have no effect on it.
- R5: With the power law and `src_is_osc_i` high, the ratio is 1, and `tick_o` is high on every cycle while the gate is set.
- R6: A divisor write loads only `wr_data_i[FIELD_LSB +: FIELD_W]` into the field. All other data bits leave the ratio unaffected.
- R7: A gate write loads `wr_data_i[GATE_BIT]`. While that bit is 0, `tick_o` and `clk_o` stay low and the phase is held at zero. When it is set, a fresh period starts from phase zero.
- R8: A new field value, or a change of `src_is_osc_i`, takes effect only at the end of the running period. `ratio_o` holds until the cycle after the terminal count. While the gate is clear, `ratio_o` follows the formula one cycle after a change.
- R9: While the gate is set, `tick_o` is high for exactly one cycle per period: the last one. A period lasts `ratio_o` cycles.
- R10: While the gate is set, `clk_o` is high for the first floor(R/2) cycles of each period of ratio R and low for the rest. This gives 50% duty for even ratios.
- R11: During reset and in the first cycle after it, `ratio_o` reads 1 and both outputs are low. The field and the gate reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parent clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_is_osc_i | input | 1 | Parent is the raw oscillator (bypass in power law) |
| wr_div_i | input | 1 | Write strobe for the divisor register |
| wr_gate_i | input | 1 | Write strobe for the gate register |
| wr_data_i | input | 32 | Write data shared by both registers |
| tick_o | output | 1 | One-cycle pulse in the last cycle of each period |
| clk_o | output | 1 | Registered divided clock level |
| ratio_o | output | RATIO_W | Effective divide ratio in use |

## Verification
One instance of each law runs side by side from a shared write bus, so a single stimulus stream exercises all four formulas against their own predictions.

Several input patterns each target a different failure:
- All-ones data around a known field shows whether the field mask or offset is wrong.
- A rewrite placed in the middle of a period shows whether the reload happens early.
- Toggling the oscillator select separates the bypass from the plain power law.
- Gate pulses show whether the phase restarts at zero.

Random writes and idle stretches then mix odd and even ratios, so the floor-half duty rule and the single-cycle tick are compared on every cycle.

// File: rtl/crd_pkg.sv
package crd_pkg;

   typedef enum logic [1:0] {
      LAW_PLUS1 = 2'd0,
      LAW_EVEN  = 2'd1,
      LAW_POW2  = 2'd2,
      LAW_CONST = 2'd3
   } div_law_e;

   // Bits needed to hold the largest ratio a law can produce.
   function automatic int ratio_width(div_law_e law, int fw, int fixed_div);
      case (law)
         LAW_PLUS1: return fw + 1;
         LAW_EVEN:  return fw + 2;
         LAW_POW2:  return (1 << fw) + 1;
         default:   return $clog2(fixed_div + 1);
      endcase
   endfunction

endpackage

// File: rtl/crd_regs.sv
module crd_regs #(
   parameter int FIELD_W = 8
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               wr_div_i,
   input  logic               wr_gate_i,
   input  logic [FIELD_W-1:0] field_wd_i,
   input  logic               gate_wd_i,
   output logic [FIELD_W-1:0] field_q_o,
   output logic               gate_q_o,
   output logic               gate_d_o
);

   logic [FIELD_W-1:0] field_q;
   logic               gate_q;

   assign gate_d_o = wr_gate_i ? gate_wd_i : gate_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         field_q <= '0;
         gate_q  <= 1'b0;
      end else begin
         if (wr_div_i) field_q <= field_wd_i;
         gate_q <= gate_d_o;
      end
   end

   assign field_q_o = field_q;
   assign gate_q_o  = gate_q;

   // R6
   field_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_div_i |=> field_q == $past(field_wd_i));

   // R7
   gate_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_gate_i |=> gate_q == $past(gate_wd_i));

endmodule

// File: rtl/crd_law.sv
module crd_law
   import crd_pkg::*;
#(
   parameter div_law_e LAW       = LAW_EVEN,
   parameter int       FIELD_W   = 8,
   parameter int       FIXED_DIV = 50,
   parameter int       RATIO_W   = 10
) (
   input  logic [FIELD_W-1:0] field_i,
   input  logic               osc_i,
   output logic [RATIO_W-1:0] ratio_o
);

   localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

   if (LAW == LAW_PLUS1) begin : g_plus1
      logic unused_osc;
      assign unused_osc = osc_i;
      assign ratio_o = RATIO_W'(field_i) + ONE;
   end else if (LAW == LAW_EVEN) begin : g_even
      logic unused_osc;
      assign unused_osc = osc_i;
      assign ratio_o = (RATIO_W'(field_i) + ONE) << 1;
   end else if (LAW == LAW_POW2) begin : g_pow2
      assign ratio_o = osc_i ? ONE : (RATIO_W'(2) << field_i);
   end else begin : g_const
      logic unused_in;
      assign unused_in = osc_i ^ (^field_i);
      assign ratio_o = RATIO_W'(FIXED_DIV);
   end

endmodule

// File: rtl/crd_core.sv
module crd_core #(
   parameter int RATIO_W = 10
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               gate_q_i,
   input  logic               gate_d_i,
   input  logic [RATIO_W-1:0] pend_i,
   output logic               tick_o,
   output logic               clk_o,
   output logic [RATIO_W-1:0] ratio_o
);

   localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

   logic [RATIO_W-1:0] cnt_q, cnt_n;
   logic [RATIO_W-1:0] act_q, act_n;
   logic               clk_q, clk_n;
   logic               last;

   assign last = (cnt_q == act_q - ONE);

   always_comb begin
      if (!gate_q_i || last) begin
         cnt_n = '0;
         act_n = pend_i;
      end else begin
         cnt_n = cnt_q + ONE;
         act_n = act_q;
      end
      clk_n = gate_d_i && (cnt_n < (act_n >> 1));
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         act_q <= ONE;
         clk_q <= 1'b0;
      end else begin
         cnt_q <= cnt_n;
         act_q <= act_n;
         clk_q <= clk_n;
      end
   end

   assign tick_o  = gate_q_i && last;
   assign clk_o   = clk_q;
   assign ratio_o = act_q;

   // R9
   cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q < act_q);

   // R9
   wrap_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> cnt_q == '0);

   // R8
   hold_ratio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gate_q_i && !tick_o) |=> $stable(act_q));

   // R7
   gated_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !gate_q_i |-> !clk_o);

endmodule

// File: rtl/clk_ratio_div.sv
module clk_ratio_div
   import crd_pkg::*;
#(
   parameter div_law_e LAW       = LAW_EVEN,
   parameter int       FIELD_W   = 8,
   parameter int       FIELD_LSB = 0,
   parameter int       GATE_BIT  = 0,
   parameter int       FIXED_DIV = 50,
   localparam int      RATIO_W   = ratio_width(LAW, FIELD_W, FIXED_DIV)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               src_is_osc_i,
   input  logic               wr_div_i,
   input  logic               wr_gate_i,
   input  logic [31:0]        wr_data_i,
   output logic               tick_o,
   output logic               clk_o,
   output logic [RATIO_W-1:0] ratio_o
);

   if (FIELD_W < 1 || FIELD_W > 16) begin : g_bad_width
      $error("clk_ratio_div: FIELD_W must lie in 1..16");
   end
   if (FIELD_LSB < 0 || FIELD_LSB + FIELD_W > 32) begin : g_bad_lsb
      $error("clk_ratio_div: field does not fit a 32-bit register");
   end
   if (GATE_BIT < 0 || GATE_BIT > 31) begin : g_bad_gate
      $error("clk_ratio_div: GATE_BIT must lie in 0..31");
   end
   if (LAW == LAW_POW2 && FIELD_W > 4) begin : g_bad_pow2
      $error("clk_ratio_div: power law limited to a 4-bit field");
   end
   if (LAW == LAW_CONST && FIXED_DIV < 1) begin : g_bad_fixed
      $error("clk_ratio_div: FIXED_DIV must be at least 1");
   end

   logic               unused_wr_bits;
   logic [FIELD_W-1:0] field_q;
   logic               gate_q, gate_d;
   logic [RATIO_W-1:0] pend;

   assign unused_wr_bits = ^wr_data_i;

   crd_regs #(
      .FIELD_W (FIELD_W)
   ) u_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_div_i   (wr_div_i),
      .wr_gate_i  (wr_gate_i),
      .field_wd_i (wr_data_i[FIELD_LSB +: FIELD_W]),
      .gate_wd_i  (wr_data_i[GATE_BIT]),
      .field_q_o  (field_q),
      .gate_q_o   (gate_q),
      .gate_d_o   (gate_d)
   );

   crd_law #(
      .LAW       (LAW),
      .FIELD_W   (FIELD_W),
      .FIXED_DIV (FIXED_DIV),
      .RATIO_W   (RATIO_W)
   ) u_law (
      .field_i (field_q),
      .osc_i   (src_is_osc_i),
      .ratio_o (pend)
   );

   crd_core #(
      .RATIO_W (RATIO_W)
   ) u_core (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .gate_q_i (gate_q),
      .gate_d_i (gate_d),
      .pend_i   (pend),
      .tick_o   (tick_o),
      .clk_o    (clk_o),
      .ratio_o  (ratio_o)
   );

endmodule

// File: tb/test_clk_ratio_div.sv
module test_clk_ratio_div;
   import crd_pkg::*;

   localparam int RW0 = ratio_width(LAW_PLUS1, 4, 50);
   localparam int RW1 = ratio_width(LAW_EVEN, 8, 50);
   localparam int RW2 = ratio_width(LAW_POW2, 2, 50);
   localparam int RW3 = ratio_width(LAW_CONST, 1, 50);

   localparam int LSB [4] = '{3, 12, 1, 0};
   localparam int FW  [4] = '{4, 8, 2, 1};
   localparam int GB  [4] = '{0, 5, 17, 31};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        osc = 1'b0;
   logic        wr_div = 1'b0;
   logic        wr_gate = 1'b0;
   logic [31:0] wr_data = '0;

   logic [RW0-1:0] r0;
   logic [RW1-1:0] r1;
   logic [RW2-1:0] r2;
   logic [RW3-1:0] r3;
   logic [17:0]    rat [4];
   logic           tk  [4];
   logic           ck  [4];

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   bit done = 1'b0;

   int mcnt [4];
   int mact [4];
   int mfld [4];
   bit mgate[4];

   always #4 clk = ~clk;

   clk_ratio_div #(.LAW(LAW_PLUS1), .FIELD_W(4), .FIELD_LSB(3), .GATE_BIT(0)) i_clk_ratio_div (
      .clk_i(clk), .rst_ni(rst_n), .src_is_osc_i(osc), .wr_div_i(wr_div), .wr_gate_i(wr_gate),
      .wr_data_i(wr_data), .tick_o(tk[0]), .clk_o(ck[0]), .ratio_o(r0));
   clk_ratio_div #(.LAW(LAW_EVEN), .FIELD_W(8), .FIELD_LSB(12), .GATE_BIT(5)) i_clk_ratio_div_even (
      .clk_i(clk), .rst_ni(rst_n), .src_is_osc_i(osc), .wr_div_i(wr_div), .wr_gate_i(wr_gate),
      .wr_data_i(wr_data), .tick_o(tk[1]), .clk_o(ck[1]), .ratio_o(r1));
   clk_ratio_div #(.LAW(LAW_POW2), .FIELD_W(2), .FIELD_LSB(1), .GATE_BIT(17)) i_clk_ratio_div_pow2 (
      .clk_i(clk), .rst_ni(rst_n), .src_is_osc_i(osc), .wr_div_i(wr_div), .wr_gate_i(wr_gate),
      .wr_data_i(wr_data), .tick_o(tk[2]), .clk_o(ck[2]), .ratio_o(r2));
   clk_ratio_div #(.LAW(LAW_CONST), .FIELD_W(1), .FIELD_LSB(0), .GATE_BIT(31), .FIXED_DIV(50)) i_clk_ratio_div_const (
      .clk_i(clk), .rst_ni(rst_n), .src_is_osc_i(osc), .wr_div_i(wr_div), .wr_gate_i(wr_gate),
      .wr_data_i(wr_data), .tick_o(tk[3]), .clk_o(ck[3]), .ratio_o(r3));

   assign rat[0] = 18'(r0);
   assign rat[1] = 18'(r1);
   assign rat[2] = 18'(r2);
   assign rat[3] = 18'(r3);

   function automatic int law_ratio(int m, int fld, bit o);
      case (m)
         0:       return fld + 1;
         1:       return 2 * (fld + 1);
         2:       return o ? 1 : (2 << fld);
         default: return 50;
      endcase
   endfunction

   function automatic string ratio_tag(int m);
      case (m)
         0:       return "R1";
         1:       return "R2";
         2:       return osc ? "R5" : "R3";
         default: return "R4";
      endcase
   endfunction

   task automatic chk(string req, string what, int actual, int expected);
      checks++;
      if (actual != expected) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, actual, expected, $time);
      end
   endtask

   task automatic model_reset();
      for (int m = 0; m < 4; m++) begin
         mcnt[m] = 0; mact[m] = 1; mfld[m] = 0; mgate[m] = 1'b0;
      end
   endtask

   task automatic model_update();
      for (int m = 0; m < 4; m++) begin
         int pend;
         pend = law_ratio(m, mfld[m], osc);
         if (!mgate[m] || mcnt[m] == mact[m] - 1) begin
            mcnt[m] = 0;
            mact[m] = pend;
         end else begin
            mcnt[m] = mcnt[m] + 1;
         end
         if (wr_div) mfld[m] = int'((wr_data >> LSB[m]) & ((32'd1 << FW[m]) - 32'd1));
         if (wr_gate) mgate[m] = wr_data[GB[m]];
      end
   endtask

   task automatic compare_all();
      for (int m = 0; m < 4; m++) begin
         chk(ratio_tag(m), $sformatf("ratio_o of law %0d", m), int'(rat[m]), mact[m]);
         chk("R9", $sformatf("tick_o of law %0d", m), int'(tk[m]),
             int'(mgate[m] && mcnt[m] == mact[m] - 1));
         chk("R10", $sformatf("clk_o of law %0d", m), int'(ck[m]),
             int'(mgate[m] && mcnt[m] < mact[m] / 2));
      end
   endtask

   task automatic step();
      @(posedge clk);
      model_update();
      #2;
      compare_all();
   endtask

   task automatic write_div(logic [31:0] d);
      wr_div = 1'b1; wr_data = d;
      step();
      wr_div = 1'b0;
   endtask

   task automatic write_gate(logic [31:0] d);
      wr_gate = 1'b1; wr_data = d;
      step();
      wr_gate = 1'b0;
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   localparam logic [31:0] ALL_GATES = (32'd1 << 0) | (32'd1 << 5) | (32'd1 << 17) | (32'd1 << 31);

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL R9 watchdog: actual cycles=%0d expected below 100000", cycles);
         report();
      end
   end

   initial begin
      int seed;
      seed = 32'd20240611;
      void'($urandom(seed));
      model_reset();
      repeat (3) @(posedge clk);
      #2;
      // R11: reset state
      for (int m = 0; m < 4; m++) begin
         chk("R11", "ratio_o in reset", int'(rat[m]), 1);
         chk("R11", "tick_o in reset", int'(tk[m]), 0);
         chk("R11", "clk_o in reset", int'(ck[m]), 0);
      end
      rst_n = 1'b1;
      step();
      step();
      // R11: ungated readback follows zero-field formula
      chk("R11", "plus-one ratio after reset", int'(rat[0]), 1);
      chk("R11", "even ratio after reset", int'(rat[1]), 2);
      chk("R11", "power ratio after reset", int'(rat[2]), 2);
      chk("R4", "constant ratio after reset", int'(rat[3]), 50);

      // R6: all ones around plus-one field value 5
      write_div(~(32'hF << 3) | (32'd5 << 3));
      step();
      chk("R6", "masked plus-one field", int'(rat[0]), 6);
      chk("R2", "even field all ones", int'(rat[1]), 512);
      chk("R3", "power field 3", int'(rat[2]), 16);
      chk("R4", "constant ignores write", int'(rat[3]), 50);

      write_div((32'd4 << 3) | (32'd2 << 12) | (32'd1 << 1));
      step();
      write_gate(ALL_GATES);
      repeat (120) step();

      // R8: rewrite in the middle of a plus-one period
      while (mcnt[0] != 1) step();
      write_div((32'd7 << 3) | (32'd2 << 12) | (32'd1 << 1));
      chk("R8", "ratio held after mid-period write", int'(rat[0]), 5);
      while (mcnt[0] != 0) step();
      chk("R8", "ratio reloaded at period end", int'(rat[0]), 8);

      // R5: oscillator bypass in the power law
      osc = 1'b1;
      repeat (20) step();
      chk("R5", "bypass ratio", int'(rat[2]), 1);
      chk("R5", "bypass tick every cycle", int'(tk[2]), 1);
      step();
      chk("R5", "bypass tick next cycle", int'(tk[2]), 1);
      osc = 1'b0;
      repeat (20) step();

      // R7: gate off silences every law
      write_gate(32'd0);
      for (int i = 0; i < 12; i++) begin
         step();
         for (int m = 0; m < 4; m++) begin
            chk("R7", "tick_o while gated off", int'(tk[m]), 0);
            chk("R7", "clk_o while gated off", int'(ck[m]), 0);
         end
      end
      write_gate(ALL_GATES);
      chk("R7", "even clk_o high at restart", int'(ck[1]), 1);
      chk("R7", "even tick_o low at restart", int'(tk[1]), 0);

      // random mix of writes, gate pulses and source changes
      for (int i = 0; i < 1500; i++) begin
         int pick;
         pick = int'($urandom % 16);
         if (pick == 0) write_div($urandom);
         else if (pick == 1) write_gate($urandom | ALL_GATES);
         else if (pick == 2 && ($urandom % 4) == 0) write_gate($urandom);
         else if (pick == 3) begin osc = ~osc; step(); end
         else step();
      end
      repeat (40) step();

      done = 1'b1;
      report();
   end

endmodule